// File: doc/BRIEF.md
# PCI Initiator Address Phase Sequencer

This block drives the address phase of a PCI bus initiator and then counts the data phases that follow. A request carries four things. The first is an already translated 64-bit address. The second is a 4-bit bus command. The third is a burst length. The fourth is a flag that marks the upper 32 address bits as nonzero. From these the block picks the address form:

- A one-beat single address cycle.
- A two-beat dual address cycle, which carries a 64-bit address.

It then asserts FRAME# and drives AD and C/BE# for each address beat. After that it asserts IRDY# for the data phases. It counts completed phases, which are the cycles with TRDY# low. FRAME# is released on the final phase.

Only memory commands may take the dual form. A request that pairs a nonzero upper address word with any other command is not placed on the bus. It is completed at once with an error indication. Each completion is returned on a valid/ready pair. The block accepts a new request only once that completion has been taken.

Top module: `pci_addr_phase_gen`

## Requirements
- R1: After reset, frame_n and irdy_n are 1, ad_oe is 0, done_valid is 0 and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. A request that is issued as a single address cycle has exactly one address beat, in the cycle after acceptance. In that beat frame_n=0, irdy_n=1, ad_oe=1, ad_out is address bits 31:0 and cbe_n is the request command.
- R3: A request with memory command and req_hi_nz=1 uses a dual address cycle. Its first beat, in the cycle after acceptance, drives address bits 31:0 with cbe_n=4'b1101 and frame_n=0.
- R4: The second dual-cycle beat follows the first at once. It drives address bits 63:32 with cbe_n equal to the memory command, frame_n=0 and ad_oe=1.
- R5: Memory commands are exactly 4'b0110, 4'b0111, 4'b1100, 4'b1110 and 4'b1111. Any other command with req_hi_nz=0 is issued as a single address cycle with its own code on cbe_n.
- R6: A non-memory command with req_hi_nz=1 produces no bus activity. In the cycle after acceptance, done_valid=1 and done_err=1, with frame_n=1 and ad_oe=0.
- R7: Data phases start in the cycle after the last address beat. irdy_n is 0, ad_oe is 0 and cbe_n is 4'b0000 in every data-phase cycle. The burst has req_len+1 data phases, each completed by a cycle with trdy_n=0.
- R8: frame_n is 0 in every data phase except the final one, and 1 during the final data phase.
- R9: A data-phase cycle with trdy_n=1 is a wait state. The same phase, with the same frame_n, is presented again in the next cycle.
- R10: One cycle after the final data phase completes, done_valid=1 with done_err=0. done_valid and done_err hold until done_ready=1. The block is idle again the next cycle, and req_ready is 1 only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 64 | Translated address |
| req_cmd | input | 4 | PCI bus command |
| req_len | input | LEN_W | Data phases minus one |
| req_hi_nz | input | 1 | Upper address word is nonzero |
| trdy_n | input | 1 | Target ready, active low |
| frame_n | output | 1 | FRAME#, active low |
| irdy_n | output | 1 | IRDY#, active low |
| ad_oe | output | 1 | AD drive enable (address beats) |
| ad_out | output | 32 | AD value during address beats |
| cbe_n | output | 4 | C/BE# value |
| done_valid | output | 1 | Completion offered |
| done_ready | input | 1 | Completion taken |
| done_err | output | 1 | Request rejected without bus activity |

## Verification
A wrong state bit shows at the ports in the very next cycle, for example a skipped second beat or a dual beat on an I/O command. It shows as a wrong cbe_n code, a missing ad_oe beat or an address word in the wrong beat. A wrong burst counter value shows within the burst as frame_n rising too early or too late, or as done_valid arriving after the wrong number of TRDY# cycles. Wait states are randomised so that a counter that moves on a stalled phase disagrees with the expected phase count.

// File: rtl/pci_apg_pkg.sv
package pci_apg_pkg;
   localparam int AD_W   = 32;
   localparam int ADDR_W = 2 * AD_W;
   localparam int CMD_W  = 4;

   localparam logic [CMD_W-1:0] CMD_DUAL = 4'b1101;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR1 = 3'd1,
      ST_ADDR2 = 3'd2,
      ST_DATA  = 3'd3,
      ST_DONE  = 3'd4
   } apg_state_e;

   function automatic logic cmd_is_memory(input logic [CMD_W-1:0] c);
      case (c)
         4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: cmd_is_memory = 1'b1;
         default:                                     cmd_is_memory = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/apg_cmd_class.sv
module apg_cmd_class
   import pci_apg_pkg::*;
#(
   parameter bit ALLOW_DAC = 1'b1
) (
   input  logic [CMD_W-1:0] cmd,
   input  logic             hi_nz,
   output logic             use_dac,
   output logic             reject
);
   generate
      if (ALLOW_DAC) begin : g_dac
         logic is_mem;
         assign is_mem  = cmd_is_memory(cmd);
         assign use_dac = is_mem & hi_nz;
         assign reject  = ~is_mem & hi_nz;
      end else begin : g_sac_only
         assign use_dac = 1'b0;
         assign reject  = hi_nz & (cmd != CMD_DUAL | cmd == CMD_DUAL);
      end
   endgenerate
endmodule

// File: rtl/apg_beat_counter.sv
module apg_beat_counter #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             step,
   output logic             last
);
   logic [LEN_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n)                     remain <= '0;
      else if (load)                  remain <= load_val;
      else if (step && remain != '0)  remain <= remain - 1'b1;
   end

   assign last = (remain == '0);
endmodule

// File: rtl/pci_addr_phase_gen.sv
module pci_addr_phase_gen
   import pci_apg_pkg::*;
#(
   parameter int LEN_W     = 4,
   parameter bit ALLOW_DAC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [63:0]       req_addr,
   input  logic [3:0]        req_cmd,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_hi_nz,
   input  logic              trdy_n,
   output logic              frame_n,
   output logic              irdy_n,
   output logic              ad_oe,
   output logic [31:0]       ad_out,
   output logic [3:0]        cbe_n,
   output logic              done_valid,
   input  logic              done_ready,
   output logic              done_err
);
   generate
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("pci_addr_phase_gen: LEN_W must lie in 1..16");
      end
      if (ADDR_W != 64 || AD_W != 32) begin : g_bad_bus
         $error("pci_addr_phase_gen: bus widths must be 32/64");
      end
   endgenerate

   apg_state_e        state, state_nx;
   logic [ADDR_W-1:0] lat_addr;
   logic [CMD_W-1:0]  lat_cmd;
   logic              lat_dac;
   logic              lat_err;
   logic              accept;
   logic              cls_dac;
   logic              cls_rej;
   logic              last_phase;
   logic              phase_done;

   apg_cmd_class #(.ALLOW_DAC(ALLOW_DAC)) u_class (
      .cmd     (req_cmd),
      .hi_nz   (req_hi_nz),
      .use_dac (cls_dac),
      .reject  (cls_rej)
   );

   assign req_ready  = (state == ST_IDLE);
   assign accept     = req_valid & req_ready;
   assign phase_done = (state == ST_DATA) & ~trdy_n;

   apg_beat_counter #(.LEN_W(LEN_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (req_len),
      .step     (phase_done),
      .last     (last_phase)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_addr <= '0;
         lat_cmd  <= '0;
         lat_dac  <= 1'b0;
         lat_err  <= 1'b0;
      end else if (accept) begin
         lat_addr <= req_addr;
         lat_cmd  <= req_cmd;
         lat_dac  <= cls_dac;
         lat_err  <= cls_rej;
      end
   end

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE:  if (accept) state_nx = cls_rej ? ST_DONE : ST_ADDR1;
         ST_ADDR1: state_nx = lat_dac ? ST_ADDR2 : ST_DATA;
         ST_ADDR2: state_nx = ST_DATA;
         ST_DATA:  if (phase_done && last_phase) state_nx = ST_DONE;
         ST_DONE:  if (done_ready) state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   always_comb begin
      frame_n = 1'b1;
      irdy_n  = 1'b1;
      ad_oe   = 1'b0;
      ad_out  = '0;
      cbe_n   = 4'hF;
      case (state)
         ST_ADDR1: begin
            frame_n = 1'b0;
            ad_oe   = 1'b1;
            ad_out  = lat_addr[AD_W-1:0];
            cbe_n   = lat_dac ? CMD_DUAL : lat_cmd;
         end
         ST_ADDR2: begin
            frame_n = 1'b0;
            ad_oe   = 1'b1;
            ad_out  = lat_addr[ADDR_W-1:AD_W];
            cbe_n   = lat_cmd;
         end
         ST_DATA: begin
            frame_n = last_phase;
            irdy_n  = 1'b0;
            cbe_n   = 4'b0000;
         end
         default: ;
      endcase
   end

   assign done_valid = (state == ST_DONE);
   assign done_err   = lat_err;
endmodule

// File: rtl/apg_checker.sv
module apg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       req_ready,
   input logic       trdy_n,
   input logic       frame_n,
   input logic       irdy_n,
   input logic       ad_oe,
   input logic [3:0] cbe_n,
   input logic       done_valid,
   input logic       done_ready,
   input logic       done_err
);
   function automatic logic mem_code(input logic [3:0] c);
      return (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
             (c == 4'b1110) || (c == 4'b1111);
   endfunction

   a_r4_dual_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (ad_oe && cbe_n == 4'b1101) |=> (ad_oe && !frame_n && mem_code(cbe_n)));

   a_r6_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_err) |-> (frame_n && irdy_n && !ad_oe));

   a_r7_more_phases: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n && !frame_n && !trdy_n) |=> !irdy_n);

   a_r8_final_phase_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n && frame_n && !trdy_n) |=> (done_valid && !done_err));

   a_r9_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n && trdy_n) |=> (!irdy_n && $stable(frame_n)));

   a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_ready) |=> (done_valid && $stable(done_err)));

   a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (frame_n && irdy_n && !done_valid));

   a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> irdy_n);
endmodule

bind pci_addr_phase_gen apg_checker u_apg_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .trdy_n     (trdy_n),
   .frame_n    (frame_n),
   .irdy_n     (irdy_n),
   .ad_oe      (ad_oe),
   .cbe_n      (cbe_n),
   .done_valid (done_valid),
   .done_ready (done_ready),
   .done_err   (done_err)
);

// File: tb/pci_addr_phase_gen_bench.sv
module pci_addr_phase_gen_bench;
   localparam int LEN_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [63:0]      req_addr = '0;
   logic [3:0]       req_cmd = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic             req_hi_nz = 1'b0;
   logic             trdy_n = 1'b1;
   logic             frame_n, irdy_n, ad_oe;
   logic [31:0]      ad_out;
   logic [3:0]       cbe_n;
   logic             done_valid, done_err;
   logic             done_ready = 1'b1;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   pci_addr_phase_gen #(.LEN_W(LEN_W)) u_pci_addr_phase_gen (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_cmd(req_cmd), .req_len(req_len),
      .req_hi_nz(req_hi_nz), .trdy_n(trdy_n), .frame_n(frame_n),
      .irdy_n(irdy_n), .ad_oe(ad_oe), .ad_out(ad_out), .cbe_n(cbe_n),
      .done_valid(done_valid), .done_ready(done_ready), .done_err(done_err)
   );

   function automatic logic exp_mem(input logic [3:0] c);
      return (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
             (c == 4'b1110) || (c == 4'b1111);
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_req(input logic [63:0] a, input logic [3:0] c, input logic hi,
                          input logic [LEN_W-1:0] len, input int wait_pct, input int hold);
      logic dac, rej;
      dac = exp_mem(c) && hi;
      rej = !exp_mem(c) && hi;
      chk("R10 req_ready while idle", req_ready, 1);
      req_valid = 1'b1; req_addr = a; req_cmd = c; req_hi_nz = hi; req_len = len;
      done_ready = (hold == 0);
      step();
      req_valid = 1'b0; req_addr = '0; req_cmd = '0; req_hi_nz = 1'b0;
      if (rej) begin
         chk("R6 reject done_valid", done_valid, 1);
         chk("R6 reject done_err", done_err, 1);
         chk("R6 reject frame_n", frame_n, 1);
         chk("R6 reject ad_oe", ad_oe, 0);
      end else begin
         chk("R2 R3 beat1 frame_n", frame_n, 0);
         chk("R2 R3 beat1 ad_oe", ad_oe, 1);
         chk("R2 R3 beat1 irdy_n", irdy_n, 1);
         chk("R2 R3 beat1 low address", ad_out, a[31:0]);
         chk(dac ? "R3 beat1 dual code" : "R2 R5 beat1 command", cbe_n, dac ? 4'b1101 : c);
         if (dac) begin
            step();
            chk("R4 beat2 high address", ad_out, a[63:32]);
            chk("R4 beat2 command", cbe_n, c);
            chk("R4 beat2 frame/oe", {frame_n, ad_oe}, 2'b01);
         end
         step();
         for (int i = 0; i <= int'(len); ) begin
            logic w;
            w = ($urandom_range(99) < wait_pct);
            trdy_n = w;
            chk("R7 data irdy_n", irdy_n, 0);
            chk("R7 data ad_oe/cbe_n", {ad_oe, cbe_n}, 5'b0_0000);
            chk(w ? "R9 wait frame_n" : "R8 data frame_n", frame_n, (i == int'(len)));
            step();
            if (!w) i++;
         end
         trdy_n = 1'b1;
         chk("R10 done_valid after final phase", done_valid, 1);
         chk("R10 done_err clear", done_err, 0);
      end
      if (hold > 0) begin
         for (int k = 0; k < hold; k++) begin
            step();
            chk("R10 done held", {done_valid, done_err}, {1'b1, rej});
            chk("R10 not ready while done", req_ready, 0);
         end
         done_ready = 1'b1;
      end
      step();
      chk("R10 back to idle", {req_ready, done_valid, frame_n, irdy_n}, 4'b1011);
   endtask

   initial begin
      logic [3:0] codes [8];
      void'($urandom(32'd5150));
      codes = '{4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111, 4'b0010, 4'b1010, 4'b0000};
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {frame_n, irdy_n, ad_oe, done_valid, req_ready}, 5'b11001);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset release", {frame_n, irdy_n, ad_oe, done_valid, req_ready}, 5'b11001);
      // directed corners
      run_req(64'h0000_0000_1234_5678, 4'b0110, 1'b0, 4'd0, 0, 0);   // R2 SAC single
      run_req(64'h89AB_CDEF_0F0F_F0F0, 4'b0111, 1'b1, 4'd0, 0, 0);   // R3 R4 DAC single
      run_req(64'h0000_0001_DEAD_BEEF, 4'b1100, 1'b1, 4'd3, 30, 0);  // R4 DAC burst
      run_req(64'h0000_0002_0000_0040, 4'b0011, 1'b1, 4'd2, 0, 0);   // R6 I/O reject
      run_req(64'h0000_0000_0000_0CF8, 4'b1010, 1'b0, 4'd0, 0, 2);   // R5 config SAC, R10 hold
      run_req(64'h0000_0000_0000_0000, 4'b0000, 1'b1, 4'd0, 0, 3);   // R6 held reject
      run_req(64'hFFFF_FFFF_FFFF_FFFC, 4'b1111, 1'b1, 4'd15, 50, 1); // R8 long burst
      // random mix
      for (int n = 0; n < 60; n++) begin
         logic [63:0] a;
         a = {$urandom(), $urandom()};
         run_req(a, codes[$urandom_range(7)], 1'($urandom_range(1)),
                 LEN_W'($urandom_range(5)), 25, $urandom_range(2));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule